// File: doc/BRIEF.md
# Interval Timer PWM Channel

This block is a register-mapped timer with three identical channels. Each channel drives one pulse-width-modulated output. A channel counts prescaled ticks up or down. In interval mode it restarts its count at a programmed limit, and this limit sets the period. A comparator sets the duty point at a programmed match value. The output can be inverted, forced to its idle level, or frozen by stopping the counter. Software sets the counter, interval and match registers and then writes the one-shot restart bit to start the waveform from a known point.

The tick source is either the system clock or an external count line. The external line goes through a synchronizer, and the bench can pick its rising or falling edge. An optional power-of-two divider sits after the tick source. The counter width is a parameter, and the data width of the register bus equals the counter width.

Top module: `ival_pwm_timer`

## Requirements
- R1: Each channel c has four word registers. Their byte addresses are 0x00+4c (tick setup), 0x0C+4c (run control), 0x24+4c (interval limit) and 0x30+4c (match point). Written values read back in the same form. The tick setup and run control registers keep bits 6:0. The interval and match registers keep CNT_W bits. A write to one channel leaves every other channel unchanged.
- R2: After reset, run control reads 0x21, every other register reads 0, and every waveform output is 0.
- R3: A read of an address that is not a register returns 0. This includes any address with bits 1:0 nonzero.
- R4: Run control bit 4 is a restart strobe and always reads back as 0. After it is written, the next tick loads the counter and drives the waveform to its active level. The load value is 0 when counting up and the interval limit when counting down.
- R5: Up counting with interval mode (run control bit 1) and match (bit 3) both set repeats with a period of I+1 ticks. The output is active for min(M, I+1) of those ticks, starting at counter value 0. Here I is the interval limit and M is the match point.
- R6: Down counting (bit 2 set) with interval mode and match also has a period of I+1 ticks. It reloads I after 0. The output is active for I-M ticks when M ≤ I and for I+1 ticks when M > I.
- R7: Tick setup bit 0 turns on the divider, and bits 4:1 hold the field N. With the divider on, one tick occurs every 2^(N+1) clocks. With it off, a tick occurs every clock and N has no effect.
- R8: With match disabled, the output stays active for the whole period.
- R9: While run control bit 0 is set, the counter and the waveform hold. Clearing the bit resumes the sequence without a restart.
- R10: While run control bit 5 is set, the output equals the polarity bit, which is its inactive level.
- R11: Run control bit 6 inverts the output, so the active level reads as 0.
- R12: Tick setup bit 5 makes the external count line the tick source, through a synchronizer. Bit 6 picks the falling edge instead of the rising edge. If the line does not move, no ticks occur.
- R13: With interval mode off, the counter does not restart at the interval limit. It runs on and wraps only at its full range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from bus_addr |
| ext_cnt_i | input | NUM_CH | External count line of each channel |
| wave_o | output | NUM_CH | Waveform output of each channel |

## Verification
The case hardest to reach from the ports is one where the waveform position depends on an event the bench cannot observe: the restart strobe lands, or the counter freezes, while the output is mid-period. The bench first lets a long-period channel pass its match point so that the output is inactive. It then writes the strobe and counts the samples, clock by clock, until the return to active level and the next fall. In the same way it stops a running channel, watches the output stay put, and resumes it without a restart to confirm the duty ratio is unchanged. For the external source, the bench toggles the count line with a lopsided pattern and compares the duty count against arithmetic on the edge rate.

// File: rtl/ival_pwm_pkg.sv
package ival_pwm_pkg;
  localparam int AW    = 8;
  localparam int PS_W  = 4;
  localparam int STRIDE = 4;

  localparam logic [AW-1:0] OFS_TICK  = 8'h00;
  localparam logic [AW-1:0] OFS_RUN   = 8'h0C;
  localparam logic [AW-1:0] OFS_LIMIT = 8'h24;
  localparam logic [AW-1:0] OFS_MATCH = 8'h30;

  typedef struct packed {
    logic            ext_fall;
    logic            ext_sel;
    logic [PS_W-1:0] div_n;
    logic            div_en;
  } tick_cfg_t;

  typedef struct packed {
    logic wave_pol;
    logic wave_off;
    logic restart;
    logic match_en;
    logic down;
    logic wrap_en;
    logic stop;
  } run_cfg_t;

  function automatic logic [AW-1:0] reg_at(logic [AW-1:0] base, int ch);
    return base + AW'(STRIDE * ch);
  endfunction
endpackage

// File: rtl/ival_tick_gen.sv
module ival_tick_gen
  import ival_pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  tick_cfg_t cfg,
  input  logic      ext_i,
  output logic      tick
);
  localparam int PRE_W = (1 << PS_W) + 1;

  logic             s1_q, s2_q, s3_q;
  logic [PRE_W-1:0] pre_q, pre_d, lim;
  logic             edge_rise, edge_fall, base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_rise = s2_q & ~s3_q;
  assign edge_fall = ~s2_q & s3_q;

  always_comb begin
    base = 1'b1;
    if (cfg.ext_sel) base = cfg.ext_fall ? edge_fall : edge_rise;
    lim  = (PRE_W'(1) << ({1'b0, cfg.div_n} + 5'd1)) - PRE_W'(1);
    tick = run & base & (~cfg.div_en | (pre_q >= lim));
    pre_d = pre_q;
    if (!cfg.div_en)         pre_d = '0;
    else if (run && base)    pre_d = tick ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/ival_pwm_chan.sv
module ival_pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart_req,
  input  logic             down,
  input  logic             wrap_en,
  input  logic             match_en,
  input  logic             wave_off,
  input  logic             wave_pol,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] match,
  output logic             wave
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nx;
  logic             lvl_q, lvl_d, pend_q, pend_d, start;

  always_comb begin
    cnt_nx = cnt_q;
    start  = 1'b0;
    if (pend_q) begin
      cnt_nx = down ? limit : '0;
      start  = 1'b1;
    end else if (down) begin
      if (cnt_q == '0) begin
        cnt_nx = wrap_en ? limit : '1;
        start  = 1'b1;
      end else begin
        cnt_nx = cnt_q - CNT_W'(1);
      end
    end else begin
      if ((wrap_en && cnt_q >= limit) || cnt_q == '1) begin
        cnt_nx = '0;
        start  = 1'b1;
      end else begin
        cnt_nx = cnt_q + CNT_W'(1);
      end
    end
  end

  always_comb begin
    cnt_d  = tick ? cnt_nx : cnt_q;
    pend_d = restart_req | (pend_q & ~tick);
    lvl_d  = lvl_q;
    if (tick) begin
      if (match_en && cnt_nx == match) lvl_d = 1'b0;
      else if (start)                  lvl_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      pend_q <= pend_d;
    end
  end

  assign wave = (lvl_q & ~wave_off) ^ wave_pol;
endmodule

// File: rtl/ival_pwm_timer.sv
module ival_pwm_timer
  import ival_pwm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] ext_cnt_i,
  output logic [NUM_CH-1:0] wave_o
);
  localparam int CFG_W = 7;
  localparam run_cfg_t RUN_RST = '{wave_pol: 1'b0, wave_off: 1'b1, restart: 1'b0,
                                   match_en: 1'b0, down: 1'b0, wrap_en: 1'b0, stop: 1'b1};

  logic [CNT_W-1:0] rd_part [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tick_cfg_t        tk_q, tk_d;
    run_cfg_t         rn_q, rn_d, rn_wr;
    logic [CNT_W-1:0] lim_q, lim_d, mt_q, mt_d;
    logic             hit_tk, hit_rn, hit_lim, hit_mt, restart_req, tick;

    assign hit_tk  = bus_addr == reg_at(OFS_TICK, c);
    assign hit_rn  = bus_addr == reg_at(OFS_RUN, c);
    assign hit_lim = bus_addr == reg_at(OFS_LIMIT, c);
    assign hit_mt  = bus_addr == reg_at(OFS_MATCH, c);

    always_comb begin
      rn_wr         = run_cfg_t'(bus_wdata[CFG_W-1:0]);
      rn_wr.restart = 1'b0;
      tk_d  = (bus_we && hit_tk)  ? tick_cfg_t'(bus_wdata[CFG_W-1:0]) : tk_q;
      rn_d  = (bus_we && hit_rn)  ? rn_wr     : rn_q;
      lim_d = (bus_we && hit_lim) ? bus_wdata : lim_q;
      mt_d  = (bus_we && hit_mt)  ? bus_wdata : mt_q;
      restart_req = bus_we & hit_rn & bus_wdata[4];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tk_q  <= '0;
        rn_q  <= RUN_RST;
        lim_q <= '0;
        mt_q  <= '0;
      end else begin
        tk_q  <= tk_d;
        rn_q  <= rn_d;
        lim_q <= lim_d;
        mt_q  <= mt_d;
      end
    end

    always_comb begin
      rd_part[c] = '0;
      if (hit_tk)       rd_part[c] = CNT_W'(tk_q);
      else if (hit_rn)  rd_part[c] = CNT_W'(rn_q);
      else if (hit_lim) rd_part[c] = lim_q;
      else if (hit_mt)  rd_part[c] = mt_q;
    end

    ival_tick_gen u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (~rn_q.stop),
      .cfg   (tk_q),
      .ext_i (ext_cnt_i[c]),
      .tick  (tick)
    );

    ival_pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .restart_req (restart_req),
      .down        (rn_q.down),
      .wrap_en     (rn_q.wrap_en),
      .match_en    (rn_q.match_en),
      .wave_off    (rn_q.wave_off),
      .wave_pol    (rn_q.wave_pol),
      .limit       (lim_q),
      .match       (mt_q),
      .wave        (wave_o[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) bus_rdata = bus_rdata | rd_part[c];
  end
endmodule

// File: rtl/ival_pwm_timer_chk.sv
module ival_pwm_timer_chk
  import ival_pwm_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic [CNT_W-1:0]  bus_rdata,
  input logic [NUM_CH-1:0] wave_o
);
  p_undef_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic stop_q, stop_d;
    localparam logic [AW-1:0] A_RUN = reg_at(OFS_RUN, c);
    localparam logic [AW-1:0] A_LIM = reg_at(OFS_LIMIT, c);
    localparam logic [AW-1:0] A_MT  = reg_at(OFS_MATCH, c);

    always_comb stop_d = (bus_we && bus_addr == A_RUN) ? bus_wdata[0] : stop_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stop_q <= 1'b1;
      else        stop_q <= stop_d;
    end

    p_wave_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_RUN && bus_wdata[5]) |=> (wave_o[c] == $past(bus_wdata[6])));

    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && $past(stop_q) && !$past(bus_we)) |-> $stable(wave_o[c]));

    p_rstbit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_RUN) |-> (bus_rdata[4] == 1'b0));

    p_limit_back_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_LIM) |=>
        (!(bus_addr == $past(bus_addr)) || bus_rdata == $past(bus_wdata)));

    p_match_back_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_MT) |=>
        (!(bus_addr == $past(bus_addr)) || bus_rdata == $past(bus_wdata)));
  end
endmodule

bind ival_pwm_timer ival_pwm_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .wave_o    (wave_o)
);

// File: tb/ival_pwm_timer_tb_top.sv
module ival_pwm_timer_tb_top;
  localparam int NCH = 3;
  localparam int CW  = 16;

  logic           clk;
  logic           rst_n;
  logic           bus_we;
  logic [7:0]     bus_addr;
  logic [CW-1:0]  bus_wdata;
  logic [CW-1:0]  bus_rdata;
  logic [NCH-1:0] ext_cnt;
  logic [NCH-1:0] wave_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  ival_pwm_timer #(.NUM_CH(NCH), .CNT_W(CW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ext_cnt_i (ext_cnt),
    .wave_o    (wave_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = CW'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
  endtask

  task automatic measure(input int ch, input int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (wave_o[ch]) hi++;
    end
  endtask

  task automatic setup(input int ch, input int tk, input int lim, input int mt, input int run);
    wr(8'(4*ch), tk);
    wr(8'(8'h24 + 4*ch), lim);
    wr(8'(8'h30 + 4*ch), mt);
    wr(8'(8'h0C + 4*ch), run);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic ext_drive(input int ncyc);
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      ext_cnt[2] = ((k % 8) < 2);
    end
    ext_cnt[2] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, hi2, p, e;
    logic v0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; ext_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    for (int c = 0; c < NCH; c++) begin
      rd(8'(4*c), 0, "R2 tick setup");
      rd(8'(8'h0C + 4*c), 'h21, "R2 run control");
      rd(8'(8'h24 + 4*c), 0, "R2 limit");
      rd(8'(8'h30 + 4*c), 0, "R2 match");
    end
    check(wave_o == '0, "R2 outputs", int'(wave_o), 0);

    // R1 readback, masking and channel separation
    for (int c = 0; c < NCH; c++) begin
      wr(8'(4*c), 'hFF80 + c);
      wr(8'(8'h24 + 4*c), 'h1230 + c);
      wr(8'(8'h30 + 4*c), 'hA500 + c);
    end
    for (int c = 0; c < NCH; c++) begin
      rd(8'(4*c), 'h00 + c, "R1 tick setup keeps 7 bits");
      rd(8'(8'h24 + 4*c), 'h1230 + c, "R1 limit");
      rd(8'(8'h30 + 4*c), 'hA500 + c, "R1 match");
    end
    wr(8'h10, 'hFFFF);
    rd(8'h10, 'h6F, "R1/R4 run control readback, strobe reads 0");
    rd(8'h0C, 'h21, "R1 other channel untouched");
    wr(8'h10, 'h21);

    // R3 unmapped
    rd(8'h18, 0, "R3 gap");
    rd(8'h3C, 0, "R3 past end");
    rd(8'h01, 0, "R3 unaligned");
    rd(8'h26, 0, "R3 unaligned");

    // R5 up-count sweep on channel 0
    for (int i = 2; i <= 6; i++) begin
      for (int m = 0; m <= i + 1; m++) begin
        setup(0, 0, i, m, 'h1A);
        p = i + 1;
        repeat (2*p + 4) @(negedge clk);
        measure(0, 2*p, hi);
        e = 2 * imin(m, i + 1);
        check(hi == e, $sformatf("R5 up I=%0d M=%0d", i, m), hi, e);
      end
    end

    // R6 down-count sweep on channel 1
    for (int i = 2; i <= 5; i++) begin
      for (int m = 0; m <= i + 1; m++) begin
        setup(1, 0, i, m, 'h1E);
        p = i + 1;
        repeat (2*p + 4) @(negedge clk);
        measure(1, 2*p, hi);
        e = (m <= i) ? 2*(i - m) : 2*(i + 1);
        check(hi == e, $sformatf("R6 down I=%0d M=%0d", i, m), hi, e);
      end
    end

    // R7 divider on channel 2, I=3 M=1
    for (int n = 0; n <= 3; n++) begin
      int s;
      s = 1 << (n + 1);
      setup(2, 1 | (n << 1), 3, 1, 'h1A);
      p = 4 * s;
      repeat (2*p + 4) @(negedge clk);
      measure(2, 2*p, hi);
      check(hi == 2*s, $sformatf("R7 divide N=%0d", n), hi, 2*s);
    end
    setup(2, 7 << 1, 3, 1, 'h1A);
    repeat (12) @(negedge clk);
    measure(2, 8, hi);
    check(hi == 2, "R7 field ignored when divider off", hi, 2);

    // R8 match disabled
    setup(1, 0, 4, 1, 'h12);
    repeat (14) @(negedge clk);
    measure(1, 10, hi);
    check(hi == 10, "R8 no match stays active", hi, 10);

    // R11 polarity
    setup(1, 0, 4, 1, 'h5A);
    repeat (14) @(negedge clk);
    measure(1, 10, hi);
    check(hi == 8, "R11 inverted", hi, 8);

    // R4 restart from low phase
    setup(0, 0, 200, 5, 'h1A);
    repeat (20) @(negedge clk);
    check(wave_o[0] == 1'b0, "R4 precondition low", wave_o[0], 0);
    wr(8'h0C, 'h1A);
    check(wave_o[0] == 1'b0, "R4 not before next tick", wave_o[0], 0);
    measure(0, 5, hi);
    check(hi == 5, "R4 active after restart", hi, 5);
    measure(0, 1, hi);
    check(hi == 0, "R4 falls at match", hi, 0);

    // R9 hold and resume
    setup(0, 0, 9, 5, 'h1A);
    repeat (27) @(negedge clk);
    wr(8'h0C, 'h0B);
    v0 = wave_o[0];
    measure(0, 30, hi);
    check(hi == (v0 ? 30 : 0), "R9 frozen output", hi, v0 ? 30 : 0);
    wr(8'h0C, 'h0A);
    repeat (3) @(negedge clk);
    measure(0, 20, hi);
    check(hi == 10, "R9 resumed duty", hi, 10);

    // R10 waveform off
    wr(8'h0C, 'h2A);
    measure(0, 20, hi);
    check(hi == 0, "R10 off at polarity 0", hi, 0);
    wr(8'h0C, 'h6A);
    measure(0, 20, hi);
    check(hi == 20, "R10 off at polarity 1", hi, 20);

    // R13 no interval restart
    setup(0, 0, 3, 5, 'h18);
    measure(0, 12, hi);
    check(hi == 5, "R13 runs past limit", hi, 5);
    measure(0, 200, hi);
    check(hi == 0, "R13 no wrap at limit", hi, 0);

    // R12 external source on channel 2
    setup(2, 'h20, 3, 2, 'h1A);
    measure(2, 40, hi);
    check(hi == 0 || hi == 40, "R12 idle line gives no ticks", hi, 0);
    measure(2, 40, hi2);
    check(hi2 == hi, "R12 idle line stable", hi2, hi);
    fork
      ext_drive(320);
      begin repeat (100) @(negedge clk); measure(2, 64, hi); end
    join
    check(hi == 32, "R12 rising edge ticks", hi, 32);
    setup(2, 'h60, 3, 2, 'h1A);
    fork
      ext_drive(320);
      begin repeat (100) @(negedge clk); measure(2, 64, hi); end
    join
    check(hi == 32, "R12 falling edge ticks", hi, 32);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule